// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes for a host. The line is oversampled by an external tick strobe that pulses sixteen times per bit period. A character is framed by a low start bit, seven or eight data bits sent least significant bit first, an optional parity bit and a high stop bit. Each finished character waits in the shift stage and then drops into a four-entry queue. The host drains the queue through a small register port.

The host port has two locations, picked by `bus_sel`. Location 0 is the data queue. A read there pops the oldest byte, and a write there does nothing. Location 1 is status. A read returns the count code, the three sticky error flags and the data-present bit. A write clears each error flag whose write bit is 0.

An interrupt request output rises once the queue holds at least the number of bytes chosen by a 2-bit level field. If the queue and the shift stage are both full and a new start bit arrives, the waiting character is dropped and the overrun flag is set.

Top module: `urx_buffered`

## Requirements
- R1: A character's data bits are stored LSB first: the first data bit after the start bit goes to bit 0, a high line level is stored as 1 and a low level as 0.
- R2: A falling edge begins a character only if the majority of the three mid-bit samples (ticks 7, 8 and 9 of the bit) is low. A shorter low pulse is discarded and stores nothing. Every data, parity and stop bit is also decided by the majority of these three samples.
- R3: The queue holds up to 4 bytes. A read with `bus_sel`=0 puts the oldest unread byte on `bus_rdata` at the next clock edge and removes it from the queue.
- R4: `rx_avail` is 1 whenever at least one unread byte is queued, and it is 0 once all bytes have been read.
- R5: `rx_count_code` is 3 for four queued bytes, 2 for three, 1 for two, and 0 for one or none.
- R6: `rx_irq` is 1 while the queued byte count is at least `cfg_irq_lvl`+1.
- R7: With `cfg_7bit`=1 a character carries 7 data bits, and bit 7 of the stored byte is 0.
- R8: With `cfg_par_en`=1 a parity bit follows the data bits. Parity is even when `cfg_par_odd`=0 and odd when it is 1. A mismatch sets `err_parity`.
- R9: A stop bit decided low sets `err_frame`, and the character is still stored.
- R10: If 4 bytes are queued, the shift stage holds a finished character and a new start bit is seen before the host reads, then `err_overrun` is set and the held character is discarded. The new character is kept, and it enters the queue once a read makes room.
- R11: The error flags reset to 0, stay set, and clear only through a status write (`bus_sel`=1) with a 0 in their bit: bit 5 for frame, bit 4 for parity, bit 3 for overrun. A status read returns {count code in bits 7:6, frame bit 5, parity bit 4, overrun bit 3, 0 in bits 2:1, data-present bit 0}.
- R12: A write with `bus_sel`=0 changes neither the queue contents nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle oversampling strobe, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| cfg_7bit | input | 1 | 1 selects 7 data bits |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity |
| cfg_irq_lvl | input | 2 | Interrupt fill level minus one |
| bus_sel | input | 1 | 0 data queue, 1 status |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_avail | output | 1 | At least one byte queued |
| rx_count_code | output | 2 | Encoded unread count |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| rx_irq | output | 1 | Receive fill-level request |

## Verification
The bench pushes a fifth and then a sixth character at a full queue. A design that declares overrun one character early, or that keeps the stale held byte, shows the wrong flag or the wrong fifth byte on readback. It also checks these cases:
- A short low glitch must store nothing; an edge-triggered start would store 0xFF.
- A 7-bit character of all ones must read back 0x7F, not 0xFF.
- A status write of all ones must leave the flags set; an inverted clear sense would drop them.
- A data-port write must leave the count unchanged; a design that treats it as a push would change it.

Random bursts of one to four bytes, with random levels, modes and parity, check the merged 0/1 count code and the interrupt threshold.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) ff[0] <= 1'b1;
          else     ff[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) ff[g] <= 1'b1;
          else     ff[g] <= ff[g-1];
        end
      end
    end
  endgenerate

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/urx_frame.sv
module urx_frame
  import urx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          cfg_7bit,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  output logic          start_seen,
  output logic          done,
  output logic          frame_bad,
  output logic          parity_bad,
  output logic [DW-1:0] data
);
  localparam int TW  = $clog2(OVS);
  localparam int IW  = $clog2(DW);
  localparam int MID = OVS / 2;

  rx_state_e      st;
  logic [TW-1:0]  tcnt;
  logic [IW-1:0]  bidx;
  logic [2:0]     votes;
  logic           acc;
  logic           bit_v;
  logic           bit_end;
  logic           in_window;
  logic [IW-1:0]  last_idx;

  assign bit_v     = maj3(votes);
  assign bit_end   = tick && (st != ST_IDLE) && (tcnt == TW'(OVS - 1));
  assign in_window = (tcnt >= TW'(MID - 1)) && (tcnt <= TW'(MID + 1));
  assign last_idx  = cfg_7bit ? IW'(DW - 2) : IW'(DW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      votes      <= '1;
      acc        <= 1'b0;
      data       <= '0;
      start_seen <= 1'b0;
      done       <= 1'b0;
      frame_bad  <= 1'b0;
      parity_bad <= 1'b0;
    end else begin
      start_seen <= 1'b0;
      done       <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          tcnt <= '0;
          if (!rxd) begin
            st         <= ST_START;
            start_seen <= 1'b1;
          end
        end else begin
          tcnt <= (tcnt == TW'(OVS - 1)) ? '0 : tcnt + 1'b1;
          if (in_window) votes <= {votes[1:0], rxd};
        end
      end
      if (bit_end) begin
        case (st)
          ST_START: begin
            if (!bit_v) begin
              st         <= ST_DATA;
              bidx       <= '0;
              acc        <= 1'b0;
              data       <= '0;
              parity_bad <= 1'b0;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_DATA: begin
            data[bidx] <= bit_v;
            acc        <= acc ^ bit_v;
            if (bidx == last_idx) st <= cfg_par_en ? ST_PAR : ST_STOP;
            else                  bidx <= bidx + 1'b1;
          end
          ST_PAR: begin
            parity_bad <= acc ^ bit_v ^ cfg_par_odd;
            st         <= ST_STOP;
          end
          ST_STOP: begin
            frame_bad <= !bit_v;
            done      <= 1'b1;
            st        <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign dout = mem[rp];
endmodule

// File: rtl/urx_buffered.sv
module urx_buffered #(
  parameter int DEPTH  = 4,
  parameter int OVS    = 16,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  logic       cfg_7bit,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_irq_lvl,
  input  logic       bus_sel,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rx_avail,
  output logic [1:0] rx_count_code,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       rx_irq
);
  localparam int DW = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic          rxd_s;
  logic          start_seen;
  logic          done;
  logic          frame_bad;
  logic          parity_bad;
  logic [DW-1:0] shift_data;
  logic [DW-1:0] fifo_dout;
  logic [CW-1:0] fifo_cnt;
  logic          shift_held;
  logic          fifo_full;
  logic          pop;
  logic          push;
  logic          ovr_set;
  logic          clr_wr;
  logic [4:0]    wdata_unused;

  assign wdata_unused = {bus_wdata[7:6], bus_wdata[2:0]};

  urx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rxd_s)
  );

  urx_frame #(.DW(DW), .OVS(OVS)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .rxd        (rxd_s),
    .cfg_7bit   (cfg_7bit),
    .cfg_par_en (cfg_par_en),
    .cfg_par_odd(cfg_par_odd),
    .start_seen (start_seen),
    .done       (done),
    .frame_bad  (frame_bad),
    .parity_bad (parity_bad),
    .data       (shift_data)
  );

  urx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .din  (shift_data),
    .pop  (pop),
    .dout (fifo_dout),
    .count(fifo_cnt)
  );

  assign fifo_full = (fifo_cnt == CW'(DEPTH));
  assign pop       = bus_rd && !bus_sel && (fifo_cnt != '0);
  assign push      = shift_held && (!fifo_full || pop);
  assign ovr_set   = start_seen && shift_held && fifo_full && !pop;
  assign clr_wr    = bus_wr && bus_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_held <= 1'b0;
    end else if (done) begin
      shift_held <= 1'b1;
    end else if (push || ovr_set) begin
      shift_held <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (done && frame_bad)           err_frame <= 1'b1;
      else if (clr_wr && !bus_wdata[5]) err_frame <= 1'b0;
      if (done && parity_bad)          err_parity <= 1'b1;
      else if (clr_wr && !bus_wdata[4]) err_parity <= 1'b0;
      if (ovr_set)                     err_overrun <= 1'b1;
      else if (clr_wr && !bus_wdata[3]) err_overrun <= 1'b0;
    end
  end

  always_comb begin
    if (fifo_cnt == '0)            rx_count_code = 2'd0;
    else if (fifo_cnt >= CW'(4))   rx_count_code = 2'd3;
    else                           rx_count_code = 2'(fifo_cnt - 1'b1);
  end

  assign rx_avail = (fifo_cnt != '0);
  assign rx_irq   = (fifo_cnt >= (CW'(cfg_irq_lvl) + CW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_sel)
        bus_rdata <= {rx_count_code, err_frame, err_parity, err_overrun, 2'b00, rx_avail};
      else
        bus_rdata <= (fifo_cnt != '0) ? fifo_dout : '0;
    end
  end
endmodule

// File: rtl/urx_buffered_chk.sv
module urx_buffered_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [7:0]    bus_wdata,
  input logic          rx_avail,
  input logic [1:0]    rx_count_code,
  input logic          err_frame,
  input logic          err_parity,
  input logic          err_overrun,
  input logic          rx_irq,
  input logic [CW-1:0] fifo_cnt
);
  p_empty_code_r5: assert property (@(posedge clk) disable iff (rst)
    !rx_avail |-> rx_count_code == 2'd0);

  p_irq_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_avail);

  p_sticky_frame_r11: assert property (@(posedge clk) disable iff (rst)
    (err_frame && !(bus_wr && bus_sel && !bus_wdata[5])) |=> err_frame);

  p_sticky_parity_r11: assert property (@(posedge clk) disable iff (rst)
    (err_parity && !(bus_wr && bus_sel && !bus_wdata[4])) |=> err_parity);

  p_sticky_overrun_r11: assert property (@(posedge clk) disable iff (rst)
    (err_overrun && !(bus_wr && bus_sel && !bus_wdata[3])) |=> err_overrun);

  p_overrun_when_full_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> $past(rx_count_code) == 2'd3);

  p_no_loss_without_read_r12: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_sel) |=> fifo_cnt >= $past(fifo_cnt));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));
endmodule

bind urx_buffered urx_buffered_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_sel      (bus_sel),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .rx_avail     (rx_avail),
  .rx_count_code(rx_count_code),
  .err_frame    (err_frame),
  .err_parity   (err_parity),
  .err_overrun  (err_overrun),
  .rx_irq       (rx_irq),
  .fifo_cnt     (fifo_cnt)
);

// File: tb/urx_buffered_tb_top.sv
module urx_buffered_tb_top;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       cfg_7bit = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] cfg_irq_lvl = 2'd0;
  logic       bus_sel = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rx_avail;
  logic [1:0] rx_count_code;
  logic       err_frame;
  logic       err_parity;
  logic       err_overrun;
  logic       rx_irq;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;
  logic [1:0] div = 2'd0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  urx_buffered dut_i (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
    .cfg_7bit(cfg_7bit), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_irq_lvl(cfg_irq_lvl), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_avail(rx_avail), .rx_count_code(rx_count_code),
    .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(input int n);
    if (n <= 1) return 2'd0;
    if (n >= 4) return 2'd3;
    return 2'(n - 1);
  endfunction

  function automatic logic [7:0] stored_of(input logic [7:0] d, input bit seven);
    return seven ? {1'b0, d[6:0]} : d;
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit seven, input bit pe,
                            input bit po, input bit bad_par, input bit bad_stop);
    logic p;
    p = po;
    rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < (seven ? 7 : 8); i++) begin
      rxd = d[i];
      p   = p ^ d[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (pe) begin
      rxd = p ^ bad_par;
      repeat (BITCLK) @(negedge clk);
    end
    rxd = !bad_stop;
    repeat (BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] v);
    @(negedge clk);
    bus_sel = sel;
    bus_rd  = 1'b1;
    @(negedge clk);
    bus_rd  = 1'b0;
    v = bus_rdata;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel   = sel;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] b [6];
    void'($urandom(32'd915));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // Reset state (R4, R5, R6, R11)
    chk("R4 reset avail", rx_avail, 0);
    chk("R5 reset code", rx_count_code, 0);
    chk("R6 reset irq", rx_irq, 0);
    chk("R11 reset flags", {err_frame, err_parity, err_overrun}, 0);
    bus_read(1'b1, v);
    chk("R11 reset status read", v, 8'h00);

    // R1: single byte, LSB first
    send_frame(8'hA6, 0, 0, 0, 0, 0);
    chk("R4 avail after one", rx_avail, 1);
    chk("R6 irq lvl0 one byte", rx_irq, 1);
    bus_read(1'b0, v);
    chk("R1 lsb-first byte", v, 8'hA6);
    chk("R4 avail after drain", rx_avail, 0);

    // R7: 7-bit mode stores 0 in bit 7
    cfg_7bit = 1'b1;
    send_frame(8'hFF, 1, 0, 0, 0, 0);
    bus_read(1'b0, v);
    chk("R7 seven bit all ones", v, 8'h7F);
    cfg_7bit = 1'b0;

    // R2: short glitch is not a start
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk("R2 glitch stores nothing", rx_avail, 0);
    chk("R2 glitch no frame error", err_frame, 0);

    // R9 framing error, char stored; R11 status layout and clear sense
    send_frame(8'h3C, 0, 0, 0, 0, 1);
    chk("R9 frame flag", err_frame, 1);
    bus_read(1'b1, v);
    chk("R11 status layout", v, 8'h21);
    bus_write(1'b1, 8'hFF);
    chk("R11 write one keeps frame", err_frame, 1);
    bus_write(1'b1, 8'hDF);
    chk("R11 write zero clears frame", err_frame, 0);
    bus_read(1'b0, v);
    chk("R9 framed char stored", v, 8'h3C);

    // R8 parity, odd
    cfg_par_en = 1'b1;
    cfg_par_odd = 1'b1;
    send_frame(8'h5B, 0, 1, 1, 0, 0);
    chk("R8 good odd parity", err_parity, 0);
    send_frame(8'h5B, 0, 1, 1, 1, 0);
    chk("R8 bad odd parity", err_parity, 1);
    bus_write(1'b1, 8'hEF);
    chk("R11 parity cleared", err_parity, 0);
    bus_read(1'b0, v);
    chk("R8 parity byte 1", v, 8'h5B);
    bus_read(1'b0, v);
    chk("R8 parity byte 2", v, 8'h5B);
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;

    // R12: data-port write ignored
    send_frame(8'h11, 0, 0, 0, 0, 0);
    send_frame(8'h22, 0, 0, 0, 0, 0);
    bus_write(1'b0, 8'hA5);
    chk("R12 code unchanged", rx_count_code, 2'd1);
    bus_read(1'b0, v);
    chk("R12 first byte intact", v, 8'h11);
    bus_read(1'b0, v);
    chk("R12 second byte intact", v, 8'h22);
    chk("R12 nothing added", rx_avail, 0);

    // R10 overrun
    for (int i = 0; i < 6; i++) b[i] = 8'($urandom());
    for (int i = 0; i < 5; i++) send_frame(b[i], 0, 0, 0, 0, 0);
    chk("R10 no overrun with held char", err_overrun, 0);
    chk("R5 full code", rx_count_code, 2'd3);
    send_frame(b[5], 0, 0, 0, 0, 0);
    chk("R10 overrun flagged", err_overrun, 1);
    for (int i = 0; i < 4; i++) begin
      bus_read(1'b0, v);
      chk("R10 queued order", v, b[i]);
    end
    bus_read(1'b0, v);
    chk("R10 newest kept, held dropped", v, b[5]);
    chk("R10 drained", rx_avail, 0);
    bus_write(1'b1, 8'hF7);
    chk("R11 overrun cleared", err_overrun, 0);

    // Random bursts: R3, R5, R6, R7, R8
    for (int it = 0; it < 15; it++) begin
      int n;
      bit sv;
      bit pe;
      bit po;
      logic [7:0] q [4];
      n  = 1 + int'($urandom_range(3));
      sv = 1'($urandom());
      pe = 1'($urandom());
      po = 1'($urandom());
      cfg_7bit    = sv;
      cfg_par_en  = pe;
      cfg_par_odd = po;
      cfg_irq_lvl = 2'($urandom());
      for (int k = 0; k < n; k++) begin
        q[k] = 8'($urandom());
        send_frame(q[k], sv, pe, po, 0, 0);
      end
      chk("R5 burst code", rx_count_code, code_of(n));
      chk("R6 burst irq", rx_irq, (n >= int'(cfg_irq_lvl) + 1) ? 1 : 0);
      chk("R8 burst no parity error", err_parity, 0);
      for (int k = 0; k < n; k++) begin
        bus_read(1'b0, v);
        chk("R3 burst order", v, stored_of(q[k], sv));
      end
      chk("R4 burst drained", rx_avail, 0);
    end

    finish_run();
  end
endmodule